// File: doc/BRIEF.md
# Display Command Stream Decoder

This block sits behind a byte-wide command channel and turns the stream into display-controller register updates and pixel-copy requests. Every command opens with the prefix byte 0xAF, which is followed by an opcode byte. A register-write command carries one address byte and then one value byte. A copy command carries seven payload bytes. Bytes that arrive outside a frame are discarded without comment. An unknown opcode raises a one-cycle error and causes input to be discarded until the next prefix.

The register bank has two copies, a live one and a shadow one. A special control address switches it between a locked and an unlocked condition. While the bank is unlocked, writes go straight to the live registers and are also announced on a write strobe. While it is locked, writes are staged in the shadow copy. Unlocking moves every staged entry into the live copy in a single commit cycle, and that is the only cycle in which the decoder holds off input. Two 24-bit base pointers and a colour-depth flag are assembled from the live registers. A read port makes any live register visible.

The framer state machine has seven states:
- IDLE: discards non-prefix bytes.
- OPCODE: waits for the opcode.
- REG_ADDR: takes the address byte.
- REG_VALUE: takes the value byte.
- COPY_PAYLOAD: counts the seven copy bytes.
- DROP: skips input after a bad opcode.
- COMMIT: the one-cycle shadow-to-live transfer.

Transitions:
- IDLE→OPCODE on a prefix.
- OPCODE→REG_ADDR on 0x20.
- OPCODE→COPY_PAYLOAD on 0x6A.
- OPCODE→OPCODE on a repeated prefix.
- OPCODE→DROP on any other byte, which also raises the error.
- REG_ADDR→REG_VALUE on any byte.
- REG_VALUE→COMMIT on an unlock while locked.
- REG_VALUE→IDLE on any other value byte.
- COPY_PAYLOAD→IDLE on its seventh byte.
- DROP→OPCODE on a prefix.
- COMMIT→IDLE unconditionally.

Top module: `cmd_stream_decoder`

## Requirements
- R1: After reset the bank is unlocked, in_ready is high, no strobe, copy or error pulse is asserted, and every live register reads 0.
- R2: With the bank unlocked, the frame 0xAF 0x20 A V (A not 0xFF) gives one wr_strobe cycle carrying A and V in the cycle after V is accepted, and live register A then reads V.
- R3: Writing value 0x00 to address 0xFF sets locked. While locked, register writes raise no strobe and leave the live registers unchanged.
- R4: Writing 0xFF to address 0xFF while locked holds in_ready low for exactly one cycle. At the end of that cycle every staged register enters the live copy at once and locked clears.
- R5: Writes to address 0xFF never appear on the write port. A value other than 0x00 or 0xFF written there, or an unlock while unlocked, changes nothing and causes no commit cycle.
- R6: The frame 0xAF 0x6A followed by seven bytes gives one cp_valid cycle after the last byte. The source is bytes 1-3 and the destination bytes 5-7, each most significant byte first, and the count is byte 4.
- R7: base16 is live registers 0x20, 0x21, 0x22 concatenated, 0x20 most significant. base8 is formed the same way from 0x26, 0x27, 0x28.
- R8: depth_is_16 is high exactly when live register 0x00 holds 0.
- R9: A byte after the prefix that is neither 0x20, 0x6A nor 0xAF raises err for one cycle. Bytes are then discarded, with no writes, until the next 0xAF.
- R10: A repeated or trailing 0xAF, and non-prefix bytes between frames, are absorbed silently. They produce no error, and the next frame decodes normally.
- R11: in_ready is low only in the commit cycle, and one byte is accepted per clock otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Input byte valid |
| in_data | input | 8 | Input byte |
| in_ready | output | 1 | Decoder accepts a byte this cycle |
| wr_strobe | output | 1 | Live register write announced |
| wr_addr | output | 8 | Address of announced write |
| wr_data | output | 8 | Data of announced write |
| locked | output | 1 | Register bank locked (writes staged) |
| rd_addr | input | 8 | Live register read address |
| rd_data | output | 8 | Live register contents at rd_addr |
| base16 | output | 24 | 16bpp base pointer from live registers |
| base8 | output | 24 | 8bpp base pointer from live registers |
| depth_is_16 | output | 1 | Colour-depth register selects 16 bits per pixel |
| cp_valid | output | 1 | Copy request pulse |
| cp_src | output | 24 | Copy source address |
| cp_count | output | 8 | Copy pixel count |
| cp_dst | output | 24 | Copy destination address |
| err | output | 1 | Unknown-opcode pulse |

## Verification
The hardest situation to reach is the commit cycle itself. To reach it, the bench must lock the bank and stage writes to several registers of one base pointer, and only then send the unlock. It then samples in the commit cycle, when the live base still holds the old value and in_ready is low, and again in the cycle after, when all staged bytes have landed together. A second hard case is the drop state after a bad opcode. The bench feeds a byte sequence that would form a valid register write if the drop were not honoured, and the scoreboard flags any write that appears.

// File: rtl/csd_pkg.sv
package csd_pkg;

    localparam logic [7:0] PREFIX_BYTE  = 8'hAF;
    localparam logic [7:0] OP_REG_WRITE = 8'h20;
    localparam logic [7:0] OP_COPY      = 8'h6A;
    localparam logic [7:0] CTRL_ADDR    = 8'hFF;
    localparam logic [7:0] LOCK_VALUE   = 8'h00;
    localparam logic [7:0] UNLOCK_VALUE = 8'hFF;
    localparam int         COPY_BYTES   = 7;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_OPCODE,
        ST_REG_ADDR,
        ST_REG_VALUE,
        ST_COPY_PAYLOAD,
        ST_DROP,
        ST_COMMIT
    } frame_state_e;

    typedef struct packed {
        logic       valid;
        logic [7:0] addr;
        logic [7:0] data;
    } reg_event_t;

endpackage

// File: rtl/csd_framer.sv
module csd_framer
    import csd_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       in_valid,
    input  logic [7:0] in_data,
    input  logic       bank_locked,
    output logic       in_ready,
    output reg_event_t reg_evt,
    output logic       copy_byte_en,
    output logic       copy_last,
    output logic       commit,
    output logic       err
);

    localparam int CNT_W = $clog2(COPY_BYTES + 1);
    localparam logic [CNT_W-1:0] LAST_IDX = CNT_W'(COPY_BYTES - 1);

    frame_state_e     state_q, state_d;
    logic [7:0]       addr_q;
    logic [CNT_W-1:0] cnt_q;
    logic             err_q;
    logic             take;

    assign take = in_valid && in_ready;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: begin
                if (take && in_data == PREFIX_BYTE) state_d = ST_OPCODE;
            end
            ST_OPCODE: begin
                if (take) begin
                    if (in_data == OP_REG_WRITE)     state_d = ST_REG_ADDR;
                    else if (in_data == OP_COPY)     state_d = ST_COPY_PAYLOAD;
                    else if (in_data == PREFIX_BYTE) state_d = ST_OPCODE;
                    else                             state_d = ST_DROP;
                end
            end
            ST_REG_ADDR: begin
                if (take) state_d = ST_REG_VALUE;
            end
            ST_REG_VALUE: begin
                if (take) begin
                    if (addr_q == CTRL_ADDR && in_data == UNLOCK_VALUE && bank_locked)
                        state_d = ST_COMMIT;
                    else
                        state_d = ST_IDLE;
                end
            end
            ST_COPY_PAYLOAD: begin
                if (take && cnt_q == LAST_IDX) state_d = ST_IDLE;
            end
            ST_DROP: begin
                if (take && in_data == PREFIX_BYTE) state_d = ST_OPCODE;
            end
            ST_COMMIT: state_d = ST_IDLE;
            default:   state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            addr_q  <= '0;
            cnt_q   <= '0;
            err_q   <= 1'b0;
        end else begin
            state_q <= state_d;
            err_q   <= take && state_q == ST_OPCODE && state_d == ST_DROP;
            if (take && state_q == ST_REG_ADDR) addr_q <= in_data;
            if (state_q != ST_COPY_PAYLOAD)     cnt_q  <= '0;
            else if (take)                      cnt_q  <= cnt_q + 1'b1;
        end
    end

    always_comb begin
        in_ready      = (state_q != ST_COMMIT);
        reg_evt.valid = take && state_q == ST_REG_VALUE;
        reg_evt.addr  = addr_q;
        reg_evt.data  = in_data;
        copy_byte_en  = take && state_q == ST_COPY_PAYLOAD;
        copy_last     = copy_byte_en && cnt_q == LAST_IDX;
        commit        = (state_q == ST_COMMIT);
        err           = err_q;
    end

endmodule

// File: rtl/csd_reg_bank.sv
module csd_reg_bank
    import csd_pkg::*;
#(
    parameter int NREG = 64
) (
    input  logic        clk,
    input  logic        rst_n,
    input  reg_event_t  reg_evt,
    input  logic        commit,
    input  logic [7:0]  rd_addr,
    output logic [7:0]  rd_data,
    output logic        locked,
    output logic        wr_strobe,
    output logic [7:0]  wr_addr,
    output logic [7:0]  wr_data,
    output logic [23:0] base16,
    output logic [23:0] base8,
    output logic        depth_is_16
);

    localparam int IDX_W = (NREG > 1) ? $clog2(NREG) : 1;
    localparam int B16_HI = 'h20;
    localparam int B8_HI  = 'h26;

    logic [7:0] live_w [NREG];
    logic       locked_q;
    logic       data_hit;
    logic       ctrl_hit;

    assign ctrl_hit = reg_evt.valid && reg_evt.addr == CTRL_ADDR;
    assign data_hit = reg_evt.valid && reg_evt.addr != CTRL_ADDR;

    for (genvar g = 0; g < NREG; g++) begin : g_entry
        logic [7:0] live_e;
        logic [7:0] shadow_e;
        logic       dirty_e;
        logic       sel_e;

        assign sel_e = data_hit && {1'b0, reg_evt.addr} == 9'(g);

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                live_e   <= '0;
                shadow_e <= '0;
                dirty_e  <= 1'b0;
            end else if (commit) begin
                if (dirty_e) live_e <= shadow_e;
                dirty_e <= 1'b0;
            end else if (sel_e) begin
                if (locked_q) begin
                    shadow_e <= reg_evt.data;
                    dirty_e  <= 1'b1;
                end else begin
                    live_e <= reg_evt.data;
                end
            end
        end

        assign live_w[g] = live_e;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            locked_q  <= 1'b0;
            wr_strobe <= 1'b0;
            wr_addr   <= '0;
            wr_data   <= '0;
        end else begin
            if (commit)
                locked_q <= 1'b0;
            else if (ctrl_hit && reg_evt.data == LOCK_VALUE)
                locked_q <= 1'b1;
            wr_strobe <= data_hit && !locked_q;
            if (data_hit && !locked_q) begin
                wr_addr <= reg_evt.addr;
                wr_data <= reg_evt.data;
            end
        end
    end

    always_comb begin
        if ({1'b0, rd_addr} < 9'(NREG))
            rd_data = live_w[rd_addr[IDX_W-1:0]];
        else
            rd_data = '0;
    end

    assign locked      = locked_q;
    assign base16      = {live_w[B16_HI], live_w[B16_HI+1], live_w[B16_HI+2]};
    assign base8       = {live_w[B8_HI], live_w[B8_HI+1], live_w[B8_HI+2]};
    assign depth_is_16 = (live_w[0] == 8'h00);

endmodule

// File: rtl/csd_copy_fields.sv
module csd_copy_fields
    import csd_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        byte_en,
    input  logic        last,
    input  logic [7:0]  data,
    output logic        cp_valid,
    output logic [23:0] cp_src,
    output logic [7:0]  cp_count,
    output logic [23:0] cp_dst
);

    localparam int SH_W = COPY_BYTES * 8;

    logic [SH_W-1:0] sh_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sh_q     <= '0;
            cp_valid <= 1'b0;
        end else begin
            cp_valid <= last;
            if (byte_en) sh_q <= {sh_q[SH_W-9:0], data};
        end
    end

    assign cp_src   = sh_q[55:32];
    assign cp_count = sh_q[31:24];
    assign cp_dst   = sh_q[23:0];

endmodule

// File: rtl/cmd_stream_decoder.sv
module cmd_stream_decoder
    import csd_pkg::*;
#(
    parameter int NREG = 64
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        in_valid,
    input  logic [7:0]  in_data,
    output logic        in_ready,
    output logic        wr_strobe,
    output logic [7:0]  wr_addr,
    output logic [7:0]  wr_data,
    output logic        locked,
    input  logic [7:0]  rd_addr,
    output logic [7:0]  rd_data,
    output logic [23:0] base16,
    output logic [23:0] base8,
    output logic        depth_is_16,
    output logic        cp_valid,
    output logic [23:0] cp_src,
    output logic [7:0]  cp_count,
    output logic [23:0] cp_dst,
    output logic        err
);

    reg_event_t reg_evt;
    logic       copy_byte_en;
    logic       copy_last;
    logic       commit;

    csd_framer u_framer (
        .clk          (clk),
        .rst_n        (rst_n),
        .in_valid     (in_valid),
        .in_data      (in_data),
        .bank_locked  (locked),
        .in_ready     (in_ready),
        .reg_evt      (reg_evt),
        .copy_byte_en (copy_byte_en),
        .copy_last    (copy_last),
        .commit       (commit),
        .err          (err)
    );

    csd_reg_bank #(.NREG(NREG)) u_bank (
        .clk         (clk),
        .rst_n       (rst_n),
        .reg_evt     (reg_evt),
        .commit      (commit),
        .rd_addr     (rd_addr),
        .rd_data     (rd_data),
        .locked      (locked),
        .wr_strobe   (wr_strobe),
        .wr_addr     (wr_addr),
        .wr_data     (wr_data),
        .base16      (base16),
        .base8       (base8),
        .depth_is_16 (depth_is_16)
    );

    csd_copy_fields u_copy (
        .clk      (clk),
        .rst_n    (rst_n),
        .byte_en  (copy_byte_en),
        .last     (copy_last),
        .data     (in_data),
        .cp_valid (cp_valid),
        .cp_src   (cp_src),
        .cp_count (cp_count),
        .cp_dst   (cp_dst)
    );

endmodule

// File: rtl/cmd_stream_decoder_checks.sv
module cmd_stream_decoder_checks (
    input logic       clk,
    input logic       rst_n,
    input logic       in_ready,
    input logic       locked,
    input logic       wr_strobe,
    input logic [7:0] wr_addr,
    input logic       err,
    input logic       cp_valid
);

    a_r11_ready_one_cycle: assert property (@(posedge clk) disable iff (!rst_n)
        !in_ready |=> in_ready);

    a_r4_unlock_after_commit: assert property (@(posedge clk) disable iff (!rst_n)
        !in_ready |=> !locked);

    a_r4_commit_only_when_locked: assert property (@(posedge clk) disable iff (!rst_n)
        !in_ready |-> locked);

    a_r3_no_strobe_locked: assert property (@(posedge clk) disable iff (!rst_n)
        locked |=> !wr_strobe);

    a_r5_ctrl_not_forwarded: assert property (@(posedge clk) disable iff (!rst_n)
        wr_strobe |-> wr_addr != 8'hFF);

    a_r9_err_single: assert property (@(posedge clk) disable iff (!rst_n)
        err |=> !err);

    a_r6_copy_single: assert property (@(posedge clk) disable iff (!rst_n)
        cp_valid |=> !cp_valid);

endmodule

bind cmd_stream_decoder cmd_stream_decoder_checks u_checks (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_ready  (in_ready),
    .locked    (locked),
    .wr_strobe (wr_strobe),
    .wr_addr   (wr_addr),
    .err       (err),
    .cp_valid  (cp_valid)
);

// File: tb/test_cmd_stream_decoder.sv
`timescale 1ns/1ps
module test_cmd_stream_decoder;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0;
    logic [7:0]  in_data = '0;
    logic        in_ready;
    logic        wr_strobe;
    logic [7:0]  wr_addr, wr_data;
    logic        locked;
    logic [7:0]  rd_addr = '0;
    logic [7:0]  rd_data;
    logic [23:0] base16, base8;
    logic        depth_is_16;
    logic        cp_valid;
    logic [23:0] cp_src, cp_dst;
    logic [7:0]  cp_count;
    logic        err;

    int checks = 0;
    int fails  = 0;
    bit done   = 0;

    logic [15:0] exp_wr [$];
    logic [55:0] exp_cp [$];
    int          exp_err = 0;

    always #5 clk = ~clk;

    cmd_stream_decoder i_cmd_stream_decoder (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_data(in_data),
        .in_ready(in_ready), .wr_strobe(wr_strobe), .wr_addr(wr_addr),
        .wr_data(wr_data), .locked(locked), .rd_addr(rd_addr), .rd_data(rd_data),
        .base16(base16), .base8(base8), .depth_is_16(depth_is_16),
        .cp_valid(cp_valid), .cp_src(cp_src), .cp_count(cp_count),
        .cp_dst(cp_dst), .err(err)
    );

    task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic send(input logic [7:0] b);
        @(negedge clk);
        in_valid = 1'b1;
        in_data  = b;
        while (!in_ready) @(negedge clk);
        @(posedge clk);
        #1 in_valid = 1'b0;
    endtask

    task automatic reg_write(input logic [7:0] a, input logic [7:0] v, input bit expect_strobe);
        if (expect_strobe) exp_wr.push_back({a, v});
        send(8'hAF); send(8'h20); send(a); send(v);
    endtask

    task automatic copy_cmd(input logic [23:0] s, input logic [7:0] n, input logic [23:0] d);
        exp_cp.push_back({s, n, d});
        send(8'hAF); send(8'h6A);
        send(s[23:16]); send(s[15:8]); send(s[7:0]);
        send(n);
        send(d[23:16]); send(d[15:8]); send(d[7:0]);
    endtask

    task automatic read_live(input string req, input logic [7:0] a, input logic [7:0] v);
        @(negedge clk);
        rd_addr = a;
        #1 chk(req, rd_data, v);
    endtask

    // scoreboard monitor
    always @(negedge clk) begin
        if (rst_n && !done) begin
            if (wr_strobe) begin
                if (exp_wr.size() == 0) begin
                    checks++; fails++;
                    $display("FAIL R2 unexpected write actual=%0h/%0h expected=none", wr_addr, wr_data);
                end else begin
                    chk("R2 write", {wr_addr, wr_data}, exp_wr.pop_front());
                end
            end
            if (cp_valid) begin
                if (exp_cp.size() == 0) begin
                    checks++; fails++;
                    $display("FAIL R6 unexpected copy actual=%0h expected=none", {cp_src, cp_count, cp_dst});
                end else begin
                    chk("R6 copy", {cp_src, cp_count, cp_dst}, exp_cp.pop_front());
                end
            end
            if (err) begin
                checks++;
                if (exp_err == 0) begin
                    fails++;
                    $display("FAIL R9/R10 unexpected err actual=1 expected=0");
                end else exp_err--;
            end
        end
    end

    initial begin
        #(200000 * 10);
        checks++; fails++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk) rst_n = 1'b1;
        // R1 reset state
        @(negedge clk);
        chk("R1 locked", locked, 0);
        chk("R1 ready", in_ready, 1);
        chk("R1 strobe", wr_strobe, 0);
        chk("R1 cp_valid", cp_valid, 0);
        chk("R1 err", err, 0);
        chk("R1 base16", base16, 0);
        read_live("R1 live 0x21", 8'h21, 8'h00);

        // R2 / R7 unlocked writes and base assembly
        reg_write(8'h20, 8'h12, 1); reg_write(8'h21, 8'h34, 1); reg_write(8'h22, 8'h56, 1);
        reg_write(8'h26, 8'hAB, 1); reg_write(8'h27, 8'hCD, 1); reg_write(8'h28, 8'hEF, 1);
        @(negedge clk);
        chk("R7 base16", base16, 24'h123456);
        chk("R7 base8", base8, 24'hABCDEF);
        read_live("R2 live 0x27", 8'h27, 8'hCD);

        // R8 colour depth
        chk("R8 depth at zero", depth_is_16, 1);
        reg_write(8'h00, 8'h01, 1);
        @(negedge clk); chk("R8 depth nonzero", depth_is_16, 0);
        reg_write(8'h00, 8'h00, 1);
        @(negedge clk); chk("R8 depth back", depth_is_16, 1);

        // R10 stray bytes, repeated and trailing prefix
        send(8'h11); send(8'h20); send(8'h05);
        exp_wr.push_back({8'h05, 8'h77});
        send(8'hAF); send(8'hAF); send(8'h20); send(8'h05); send(8'h77);
        send(8'hAF);
        repeat (3) @(negedge clk);
        chk("R10 no err after trailing prefix", err, 0);
        reg_write(8'h06, 8'h88, 1);
        read_live("R10 live 0x05", 8'h05, 8'h77);
        read_live("R10 live 0x06", 8'h06, 8'h88);

        // R3 lock, staged writes
        reg_write(8'hFF, 8'h00, 0);
        @(negedge clk); chk("R3 locked set", locked, 1);
        reg_write(8'h21, 8'h99, 0);
        reg_write(8'h22, 8'hAA, 0);
        reg_write(8'hFF, 8'h55, 0);
        @(negedge clk);
        chk("R3 live base unchanged", base16, 24'h123456);
        chk("R5 odd ctrl value keeps lock", locked, 1);
        read_live("R3 live 0x21 unchanged", 8'h21, 8'h34);

        // R4 commit
        reg_write(8'hFF, 8'hFF, 0);
        @(negedge clk);
        chk("R4 ready low in commit", in_ready, 0);
        chk("R4 lock held in commit", locked, 1);
        chk("R4 live old in commit", base16, 24'h123456);
        @(negedge clk);
        chk("R11 ready back", in_ready, 1);
        chk("R4 lock cleared", locked, 0);
        chk("R4 staged landed", base16, 24'h1299AA);

        // R5 unlock while unlocked: no commit cycle
        reg_write(8'hFF, 8'hFF, 0);
        @(negedge clk);
        chk("R5 no commit when unlocked", in_ready, 1);
        chk("R5 still unlocked", locked, 0);

        // R6 copies
        copy_cmd(24'h010203, 8'h10, 24'h040506);
        copy_cmd(24'hFEDCBA, 8'h01, 24'h000000);
        @(negedge clk);

        // R9 unknown opcode, then drop
        exp_err++;
        send(8'hAF); send(8'h33);
        send(8'h20); send(8'h07); send(8'h55);
        reg_write(8'h07, 8'h66, 1);
        read_live("R9 live 0x07", 8'h07, 8'h66);

        repeat (4) @(negedge clk);
        chk("R2 queue drained", exp_wr.size(), 0);
        chk("R6 queue drained", exp_cp.size(), 0);
        chk("R9 err seen", exp_err, 0);
        done = 1;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

endmodule